// File: doc/BRIEF.md
# Double-Buffered Audio DMA Interface

This block is a memory-mapped playback engine for stereo PCM audio. Software writes a buffer start address and then a byte length. The length write places the transfer in a two-entry queue that holds one active transfer and one waiting transfer. While playback is enabled, the engine reads one 32-bit word per stereo frame over a simple request/acknowledge memory port. A frame holds a signed 16-bit left sample in the upper half and a signed 16-bit right sample in the lower half.

A programmable divider sets the frame rate. At each frame the engine presents the two samples in parallel. It also shifts them out MSB first on a serial DAC link that has its own bit-clock divider. When the last word of the active transfer has been fetched, the waiting transfer moves up and an interrupt is raised. Software acknowledges the interrupt and refills the free slot, so it normally runs about one buffer ahead of playback.

The register file has six word offsets. Offset 0 is the address and offset 1 is the length. Offset 2 is the control register and offset 3 is the status register. Offset 4 is the frame-rate divider and offset 5 is the bit-clock divider. Register reads are combinational.

Top module: `audio_dma_engine`

## Requirements
- R1: After reset the status reads 0, `irq` is low, `mem_req` is low and `pcm_valid` is low.
- R2: A write to offset 0 stores the address with its low 3 bits forced to zero, and offset 0 reads back that aligned value. Fetch addresses are the stored address plus 4 times the word index.
- R3: A write to offset 1 clears the low 3 bits of the written value. If the result is non-zero, a transfer of that many bytes at the current address is enqueued. A result of zero enqueues nothing.
- R4: The status register at offset 3 reads bit 31 = 1 when two transfers are queued and bit 30 = 1 when at least one transfer is queued. All other bits read 0.
- R5: A length write while the queue is full is discarded, and the transfers already queued are unchanged.
- R6: Control bit 0 at offset 2 enables playback. While it is 0, no new memory request is issued and no frame is produced. Setting it again resumes from the point where playback stopped.
- R7: `mem_req` stays high with a stable `mem_addr` until `mem_ack`. Frames carry the fetched words in queue order and in address order.
- R8: With divider D at offset 4, consecutive frames are D+1 clock cycles apart.
- R9: Each frame shows `mem_rdata[31:16]` on `pcm_left` and `mem_rdata[15:0]` on `pcm_right`. The serial link shifts out the 32 bits MSB first, one bit per `dac_bclk` rising edge. With divider B at offset 5, `dac_bclk` toggles every B+1 cycles. `dac_lrclk` is high during the 16 left bits.
- R10: `irq` rises one cycle after the last word of the active transfer is fetched, at the same time as the waiting transfer moves up. It stays high until any write to offset 3.
- R11: When a frame is due and no fetched word is waiting, the frame is all zeros. With no transfer queued, busy reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_ack | input | 1 | Memory read data valid |
| mem_rdata | input | 32 | Memory read data |
| pcm_valid | output | 1 | One-cycle frame strobe |
| pcm_left | output | 16 | Left sample of the frame |
| pcm_right | output | 16 | Right sample of the frame |
| dac_bclk | output | 1 | Serial bit clock |
| dac_lrclk | output | 1 | Channel select, high for left |
| dac_sdata | output | 1 | Serial sample data |
| irq | output | 1 | Transfer-retired interrupt |

## Verification
Register reads are combinational, so a value is due in the same cycle that its offset is applied. Status and interrupt changes are due at the edge that takes the write or the retiring fetch, and the bench samples them at the following falling edge. A frame strobe follows its divider tick by one register. The serial MSB is on `dac_sdata` together with the strobe, and the first `dac_bclk` rise comes B+1 cycles later. The bench therefore samples every output at the falling clock edge, measures frame spacing and bit-clock spacing in counted cycles, and answers memory requests half a cycle after they appear.

// File: rtl/adma_pkg.sv
package adma_pkg;

  typedef enum logic [2:0] {
    RO_ADDR = 3'd0,
    RO_LEN  = 3'd1,
    RO_CTRL = 3'd2,
    RO_STAT = 3'd3,
    RO_RATE = 3'd4,
    RO_BCLK = 3'd5
  } adma_reg_e;

  localparam int unsigned WORD_BYTES = 4;

  // Clears the three low bits: buffers are 8-byte granular.
  function automatic logic [31:0] align8(input logic [31:0] v);
    return {v[31:3], 3'b000};
  endfunction

  // True when the word at byte offset off is the final word of a len-byte buffer.
  function automatic logic fetch_is_last(input logic [31:0] off, input logic [31:0] len);
    return (off + WORD_BYTES) >= len;
  endfunction

  function automatic logic [31:0] status_word(input logic full, input logic busy);
    return {full, busy, 30'd0};
  endfunction

endpackage

// File: rtl/adma_divider.sv
module adma_divider #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         restart,
  input  logic [W-1:0] limit,
  output logic         tick
);
  logic [W-1:0] cnt;

  assign tick = run && !restart && (cnt >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n)                       cnt <= '0;
    else if (!run || restart || tick) cnt <= '0;
    else                              cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/adma_queue.sv
module adma_queue #(
  parameter int AW = 24,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [LW-1:0] push_len,
  input  logic          pop,
  output logic [AW-1:0] head_addr,
  output logic [LW-1:0] head_len,
  output logic          nonempty,
  output logic          full,
  output logic          drop
);
  localparam int DEPTH = 2;

  logic [AW-1:0] s_addr [DEPTH];
  logic [LW-1:0] s_len  [DEPTH];
  logic [1:0]    cnt;
  logic          push_ok;
  logic          wr_idx;

  assign full      = (cnt == 2'(DEPTH));
  assign nonempty  = (cnt != 2'd0);
  assign drop      = push && full;
  assign push_ok   = push && !full;
  assign wr_idx    = pop ? (cnt == 2'd2) : (cnt == 2'd1);
  assign head_addr = s_addr[0];
  assign head_len  = s_len[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        s_addr[i] <= '0;
        s_len[i]  <= '0;
      end
    end else begin
      if (pop) begin
        s_addr[0] <= s_addr[1];
        s_len[0]  <= s_len[1];
      end
      if (push_ok) begin
        s_addr[wr_idx] <= push_addr;
        s_len[wr_idx]  <= push_len;
      end
      cnt <= cnt + 2'(push_ok) - 2'(pop);
    end
  end
endmodule

// File: rtl/adma_fetch.sv
module adma_fetch
  import adma_pkg::*;
#(
  parameter int AW = 24,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          have_xfer,
  input  logic [AW-1:0] head_addr,
  input  logic [LW-1:0] head_len,
  input  logic          consume,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   buf_word,
  output logic          buf_valid,
  output logic          retire
);
  logic [LW-1:0] off;
  logic          done;
  logic          is_last;

  assign mem_addr = head_addr + AW'(off);
  assign done     = mem_req && mem_ack;
  assign is_last  = fetch_is_last(32'(off), 32'(head_len));
  assign retire   = done && is_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off       <= '0;
      mem_req   <= 1'b0;
      buf_word  <= '0;
      buf_valid <= 1'b0;
    end else begin
      if (consume) buf_valid <= 1'b0;
      if (done) begin
        mem_req   <= 1'b0;
        buf_word  <= mem_rdata;
        buf_valid <= 1'b1;
        off       <= is_last ? '0 : off + LW'(WORD_BYTES);
      end else if (!mem_req && enable && have_xfer && (!buf_valid || consume)) begin
        mem_req <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/adma_serial.sv
module adma_serial #(
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_tick,
  input  logic          buf_valid,
  input  logic [31:0]   buf_word,
  input  logic [BW-1:0] bdiv,
  output logic          pcm_valid,
  output logic [15:0]   pcm_left,
  output logic [15:0]   pcm_right,
  output logic          dac_bclk,
  output logic          dac_lrclk,
  output logic          dac_sdata
);
  localparam int FRAME_BITS = 32;
  localparam int CW = $clog2(FRAME_BITS + 1);

  logic [31:0]   shreg;
  logic [CW-1:0] bitcnt;
  logic          bit_tick;
  logic [31:0]   frame_word;

  assign frame_word = buf_valid ? buf_word : 32'd0;
  assign dac_sdata  = shreg[31];
  assign dac_lrclk  = (bitcnt < CW'(FRAME_BITS / 2));

  adma_divider #(.W(BW)) u_bdiv (
    .clk(clk), .rst_n(rst_n), .run(1'b1), .restart(frame_tick),
    .limit(bdiv), .tick(bit_tick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcm_valid <= 1'b0;
      pcm_left  <= '0;
      pcm_right <= '0;
      shreg     <= '0;
      bitcnt    <= CW'(FRAME_BITS);
      dac_bclk  <= 1'b0;
    end else begin
      pcm_valid <= frame_tick;
      if (frame_tick) begin
        pcm_left  <= frame_word[31:16];
        pcm_right <= frame_word[15:0];
        shreg     <= frame_word;
        bitcnt    <= '0;
        dac_bclk  <= 1'b0;
      end else if (bit_tick) begin
        dac_bclk <= ~dac_bclk;
        if (dac_bclk) begin
          shreg <= {shreg[30:0], 1'b0};
          if (bitcnt != CW'(FRAME_BITS)) bitcnt <= bitcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/audio_dma_engine.sv
module audio_dma_engine
  import adma_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 16,
  parameter int RATE_W = 14,
  parameter int BCLK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              pcm_valid,
  output logic [15:0]       pcm_left,
  output logic [15:0]       pcm_right,
  output logic              dac_bclk,
  output logic              dac_lrclk,
  output logic              dac_sdata,
  output logic              irq
);
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic              ctl_en;
  logic [RATE_W-1:0] rate_q;
  logic [BCLK_W-1:0] bdiv_q;
  logic              irq_q;

  logic [31:0]       wdata_al;
  logic [LEN_W-1:0]  len_in;
  logic              len_wr, push_evt, ack_evt;
  logic              retire_evt, drop_evt, underflow_evt, frame_tick;
  logic              q_full, q_busy;
  logic [ADDR_W-1:0] head_addr;
  logic [LEN_W-1:0]  head_len;
  logic [31:0]       buf_word;
  logic              buf_valid;

  assign wdata_al = align8(reg_wdata);
  assign len_in   = LEN_W'(wdata_al);
  assign len_wr   = reg_we && (reg_addr == RO_LEN);
  assign push_evt = len_wr && (len_in != '0);
  assign ack_evt  = reg_we && (reg_addr == RO_STAT);
  assign underflow_evt = frame_tick && !buf_valid;
  assign irq      = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      len_q  <= '0;
      ctl_en <= 1'b0;
      rate_q <= '0;
      bdiv_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          RO_ADDR: addr_q <= ADDR_W'(wdata_al);
          RO_LEN:  len_q  <= len_in;
          RO_CTRL: ctl_en <= reg_wdata[0];
          RO_RATE: rate_q <= RATE_W'(reg_wdata);
          RO_BCLK: bdiv_q <= BCLK_W'(reg_wdata);
          default: ;
        endcase
      end
      if (retire_evt)   irq_q <= 1'b1;
      else if (ack_evt) irq_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      RO_ADDR: reg_rdata = 32'(addr_q);
      RO_LEN:  reg_rdata = 32'(len_q);
      RO_CTRL: reg_rdata = {31'd0, ctl_en};
      RO_STAT: reg_rdata = status_word(q_full, q_busy);
      RO_RATE: reg_rdata = 32'(rate_q);
      RO_BCLK: reg_rdata = 32'(bdiv_q);
      default: reg_rdata = 32'd0;
    endcase
  end

  adma_queue #(.AW(ADDR_W), .LW(LEN_W)) u_queue (
    .clk(clk), .rst_n(rst_n), .push(push_evt), .push_addr(addr_q),
    .push_len(len_in), .pop(retire_evt), .head_addr(head_addr),
    .head_len(head_len), .nonempty(q_busy), .full(q_full), .drop(drop_evt)
  );

  adma_divider #(.W(RATE_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .run(ctl_en), .restart(1'b0),
    .limit(rate_q), .tick(frame_tick)
  );

  adma_fetch #(.AW(ADDR_W), .LW(LEN_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .enable(ctl_en), .have_xfer(q_busy),
    .head_addr(head_addr), .head_len(head_len), .consume(frame_tick),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .buf_word(buf_word), .buf_valid(buf_valid),
    .retire(retire_evt)
  );

  adma_serial #(.BW(BCLK_W)) u_serial (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .buf_valid(buf_valid),
    .buf_word(buf_word), .bdiv(bdiv_q), .pcm_valid(pcm_valid),
    .pcm_left(pcm_left), .pcm_right(pcm_right), .dac_bclk(dac_bclk),
    .dac_lrclk(dac_lrclk), .dac_sdata(dac_sdata)
  );
endmodule

// File: rtl/adma_checker.sv
module adma_checker #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic          irq,
  input logic          pcm_valid,
  input logic [15:0]   pcm_left,
  input logic [15:0]   pcm_right,
  input logic          ctl_en,
  input logic          retire_evt,
  input logic          ack_evt,
  input logic          underflow_evt,
  input logic          drop_evt,
  input logic          q_full
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R7
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    retire_evt |=> irq); // R10
  AST_IRQ_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ack_evt && !retire_evt |=> !irq); // R10
  AST_NO_FETCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en && !mem_req |=> !mem_req); // R6
  AST_NO_FRAME_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> !pcm_valid); // R6
  AST_ZERO_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_evt |=> pcm_valid && pcm_left == 16'd0 && pcm_right == 16'd0); // R11
  AST_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt && !retire_evt |=> q_full); // R5
endmodule

bind audio_dma_engine adma_checker #(.AW(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .irq(irq), .pcm_valid(pcm_valid),
  .pcm_left(pcm_left), .pcm_right(pcm_right), .ctl_en(ctl_en),
  .retire_evt(retire_evt), .ack_evt(ack_evt), .underflow_evt(underflow_evt),
  .drop_evt(drop_evt), .q_full(q_full)
);

// File: tb/sim_audio_dma_engine.sv
`timescale 1ns/1ps
module sim_audio_dma_engine;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_ack = 1'b0;
  logic [31:0]   mem_rdata = '0;
  logic          pcm_valid;
  logic [15:0]   pcm_left, pcm_right;
  logic          dac_bclk, dac_lrclk, dac_sdata, irq;

  always #2.5 clk = ~clk;

  audio_dma_engine u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .pcm_valid(pcm_valid), .pcm_left(pcm_left), .pcm_right(pcm_right),
    .dac_bclk(dac_bclk), .dac_lrclk(dac_lrclk), .dac_sdata(dac_sdata), .irq(irq)
  );

  int n_cmp = 0, n_bad = 0;
  logic [31:0] exp_w [0:255];
  int exp_n = 0, play_idx = 0, cyc = 0, last_frame = -1, cur_d = 0;
  int irq_seen = 0;

  function automatic logic [31:0] memdata(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A_0000;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory stub: answers half a cycle after a request appears.
  initial forever begin
    @(negedge clk);
    if (mem_req && !mem_ack) begin
      mem_ack   = 1'b1;
      mem_rdata = memdata(32'(mem_addr));
    end else begin
      mem_ack = 1'b0;
    end
  end

  // Frame monitor: order, content, zero fill and spacing.
  initial forever begin
    @(negedge clk);
    cyc++;
    if (rst_n && pcm_valid) begin
      logic [31:0] e;
      e = (play_idx < exp_n) ? exp_w[play_idx] : 32'd0;
      if (play_idx < exp_n) begin
        chk({pcm_left, pcm_right} == e, "R7/R9 frame word", {pcm_left, pcm_right}, e);
        play_idx++;
      end else begin
        chk({pcm_left, pcm_right} == 32'd0, "R11 zero frame", {pcm_left, pcm_right}, 32'd0);
      end
      if (last_frame >= 0)
        chk(cyc - last_frame == cur_d + 1, "R8 frame period", 32'(cyc - last_frame), 32'(cur_d + 1));
      last_frame = cyc;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic push(input logic [31:0] a, input logic [31:0] len, input logic accepted);
    wr(3'd0, a);
    wr(3'd1, len);
    if (accepted)
      for (int k = 0; k < int'(len[31:3]) * 2; k++) begin
        exp_w[exp_n] = memdata({a[31:3], 3'b000} + 32'(4 * k));
        exp_n++;
      end
  endtask

  task automatic wait_irq(input int maxc, output logic got);
    got = 1'b0;
    for (int i = 0; i < maxc && !got; i++) begin
      @(negedge clk);
      if (irq) got = 1'b1;
    end
  endtask

  task automatic ack_irq();
    irq_seen++;
    wr(3'd3, 32'hFFFF_FFFF);
    chk(irq == 1'b0, "R10 irq cleared by status write", 32'(irq), 32'd0);
  endtask

  task automatic wait_played(input int maxc);
    for (int i = 0; i < maxc && play_idx < exp_n; i++) @(negedge clk);
    chk(play_idx == exp_n, "R7 all queued words played", 32'(play_idx), 32'(exp_n));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", play_idx, exp_n);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic got;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    rd(3'd3, v);
    chk(v == 32'd0, "R1 status after reset", v, 32'd0);
    chk(irq == 1'b0 && mem_req == 1'b0 && pcm_valid == 1'b0, "R1 idle outputs",
        {29'd0, irq, mem_req, pcm_valid}, 32'd0);

    // R3: a length that masks to zero enqueues nothing
    push(32'h500, 32'd5, 1'b0);
    rd(3'd3, v);
    chk(v == 32'd0, "R3 zero length ignored", v, 32'd0);

    // R2: address alignment
    wr(3'd0, 32'h1007);
    rd(3'd0, v);
    chk(v == 32'h1000, "R2 aligned address readback", v, 32'h1000);

    // R3/R4: enqueue, busy then full
    push(32'h1007, 32'h13, 1'b1);
    rd(3'd3, v);
    chk(v == 32'h4000_0000, "R4 busy with one queued", v, 32'h4000_0000);
    push(32'h2000, 32'd8, 1'b1);
    rd(3'd3, v);
    chk(v == 32'hC000_0000, "R4 full with two queued", v, 32'hC000_0000);
    push(32'h3000, 32'd8, 1'b0);
    rd(3'd3, v);
    chk(v == 32'hC000_0000, "R5 write while full discarded", v, 32'hC000_0000);

    // Start playback with a slow frame rate and B=1
    wr(3'd4, 32'd199);
    wr(3'd5, 32'd1);
    cur_d = 199; last_frame = -1;
    wr(3'd2, 32'd1);

    // R9: serial shape of the first frame
    while (!pcm_valid) @(negedge clk);
    begin
      logic [31:0] bits = '0;
      logic prev = dac_bclk;
      int nb = 0, last_rise = -1, lr_first = 0, lr_17 = 1;
      int gap_bad = 0;
      for (int i = 0; i < 400 && nb < 32; i++) begin
        @(negedge clk);
        if (dac_bclk && !prev) begin
          if (nb == 0) lr_first = int'(dac_lrclk);
          if (nb == 16) lr_17 = int'(dac_lrclk);
          if (last_rise >= 0 && cyc - last_rise != 4) gap_bad++;
          last_rise = cyc;
          bits = {bits[30:0], dac_sdata};
          nb++;
        end
        prev = dac_bclk;
      end
      chk(bits == memdata(32'h1000), "R9 serial bits MSB first", bits, memdata(32'h1000));
      chk(gap_bad == 0, "R9 bit clock period 2*(B+1)", 32'(gap_bad), 32'd0);
      chk(lr_first == 1 && lr_17 == 0, "R9 lrclk high for left half",
          32'({lr_first[0], lr_17[0]}), 32'h2);
    end

    // R10: interrupt on retire, promotion of the queued transfer
    wait_irq(2000, got);
    chk(got, "R10 irq after first transfer", 32'(got), 32'd1);
    ack_irq();
    rd(3'd3, v);
    chk(v == 32'h4000_0000, "R10 queued transfer promoted", v, 32'h4000_0000);
    wait_irq(2000, got);
    chk(got, "R10 irq after second transfer", 32'(got), 32'd1);
    ack_irq();
    wait_played(3000);
    repeat (700) @(negedge clk);
    rd(3'd3, v);
    chk(v == 32'd0, "R11 busy clear when empty", v, 32'd0);

    // R6: disable stops fetching and frames, enable resumes
    wr(3'd2, 32'd0);
    push(32'h4000, 32'd32, 1'b1);
    last_frame = -1;
    wr(3'd2, 32'd1);
    begin
      int target = play_idx + 2;
      for (int i = 0; i < 2000 && play_idx < target; i++) @(negedge clk);
    end
    repeat (20) @(negedge clk);
    wr(3'd2, 32'd0);
    repeat (2) @(negedge clk);
    begin
      int nf = 0, nr = 0;
      for (int i = 0; i < 1000; i++) begin
        @(negedge clk);
        if (pcm_valid) nf++;
        if (mem_req) nr++;
      end
      chk(nf == 0, "R6 no frames while disabled", 32'(nf), 32'd0);
      chk(nr == 0, "R6 no fetch while disabled", 32'(nr), 32'd0);
    end
    last_frame = -1;
    wr(3'd2, 32'd1);
    wait_irq(3000, got);
    chk(got, "R10 irq after resumed transfer", 32'(got), 32'd1);
    ack_irq();
    wait_played(3000);
    repeat (300) @(negedge clk);

    // Random phase: fast frames, software refills on each interrupt
    wr(3'd2, 32'd0);
    wr(3'd4, 32'd11);
    wr(3'd5, 32'd0);
    cur_d = 11; last_frame = -1;
    irq_seen = 0;
    begin
      int pushed = 0;
      void'($urandom(32'd1234));
      for (int k = 0; k < 2; k++) begin
        push($urandom() & 32'h00FF_FFF8, 32'(8 * (1 + ($urandom() % 4))), 1'b1);
        pushed++;
      end
      wr(3'd2, 32'd1);
      while (irq_seen < 20) begin
        wait_irq(2000, got);
        if (!got) break;
        ack_irq();
        if (pushed < 20) begin
          push(($urandom() & 32'h00FF_FFFF) | 32'(($urandom() % 2) * 3),
               32'(8 * (1 + ($urandom() % 4))), 1'b1);
          pushed++;
        end
      end
      chk(irq_seen == 20, "R10 one irq per transfer", 32'(irq_seen), 32'd20);
    end
    wait_played(3000);
    repeat (60) @(negedge clk);
    rd(3'd3, v);
    chk(v == 32'd0, "R11 status idle after random run", v, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule